// File: doc/BRIEF.md
# Phase-Staggered Four-Channel PWM Group

This block drives four PWM outputs as one coordinated group. All four share one period of P ticks and one active length. Their counters begin a quarter period apart, so the four pulse trains are evenly spread in phase. The group runs in finite mode: once launched, it produces a programmed number of periods. It then reports completion and parks every output at its inactive level.

Ticks come from a fixed divider on the block clock: one tick every PRESCALE+1 clock cycles. The default PRESCALE is 239, so the counters advance once every 240 clocks. The polarity input selects two things together: active-high outputs with the phase offsets rising from channel 0, or active-low outputs with the phase offsets falling from channel 0.

Launch is gated three ways: a group enable, a group start, and a nibble of four channel enables. Stopping is done by dropping start, or any of the other gates.

Top module: `pwm_phase_group`

## Requirements
- R1: While reset is asserted, and after it is released with `cfg_invert` low, every PWM output is low and `grp_done` is low.
- R2: The group launches only in a cycle where `grp_enable`, `grp_start` and all four bits of `ch_enable` are high together. The launch takes effect at that clock edge, and the first pattern appears right after it. While any one of these inputs is low, the outputs stay at the idle level and `grp_done` stays low.
- R3: With `cfg_invert` low, channel i (i = 0..3) starts its counter at i·⌊2P/8⌋. Each counter advances by one per tick and wraps from P−1 to 0.
- R4: With `cfg_invert` high, channel i starts its counter at ⌊6P/8⌋ − i·⌊2P/8⌋, and every output is active-low.
- R5: A channel is active while its counter is below ⌊3P/8⌋. An active channel drives 1 for normal polarity and 0 for inverted polarity.
- R6: The counters advance exactly once every PRESCALE+1 clock cycles while the group runs. The first advance comes PRESCALE+1 cycles after the launch edge.
- R7: A run lasts N·P ticks, where N is `cfg_pulses`. After the last tick, `grp_done` goes high and all outputs sit at the inactive level of the captured polarity. This state holds for as long as `grp_enable` and `grp_start` both stay high.
- R8: Launching with N = 0 raises `grp_done` at the launch edge, and no channel is ever active.
- R9: While running, dropping `grp_start`, `grp_enable` or any `ch_enable` bit stops the group at the next edge. The outputs then go to the idle level and `grp_done` stays low.
- R10: The period, the pulse count and the polarity are captured at launch. Changing them during a run has no effect on the outputs or on the run length.
- R11: While idle (not running and not done), every output follows the live `cfg_invert` value. When the group leaves the done state, it returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | 16 | Group period P in ticks |
| cfg_pulses | input | 16 | Number of periods N to run |
| cfg_invert | input | 1 | Polarity select: 1 gives active-low outputs and a falling phase order |
| grp_enable | input | 1 | Group enable |
| grp_start | input | 1 | Group start; clear it to stop or to re-arm after done |
| ch_enable | input | 4 | Per-channel enables; all four must be set to launch |
| pwm_out | output | 4 | PWM outputs, channel 0 in bit 0 |
| grp_done | output | 1 | High once the programmed run has completed |

## Verification
On every cycle, the bound checker watches several behaviours:
- the idle and done output levels;
- that no launch happens without all gates;
- the one-cycle abort;
- the immediate completion for a zero pulse count;
- that the captured configuration stays stable during a run;
- the counter range;
- the exact tick spacing.

Other behaviours only the directed scenarios can show. These are the actual phase pattern of each channel at every tick, in both polarities and for a period that does not divide by eight. The scenarios also show that a run lasts exactly N·P ticks, and that a launch or a relaunch produces the right first pattern.

// File: rtl/pwmgrp_pkg.sv
package pwmgrp_pkg;
  parameter int PER_W = 16;
  parameter int NUM_W = 16;
  parameter int NCH   = 4;
  localparam int EXT_W = PER_W + 3;

  typedef logic [PER_W-1:0] per_t;
  typedef logic [NUM_W-1:0] num_t;
  typedef logic [EXT_W-1:0] ext_t;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_RUN  = 2'd1,
    GS_DONE = 2'd2
  } gstate_e;

  // floor(k * p / 8) for k in 0..7, built from shifted partial sums
  function automatic per_t eighths(per_t p, int k);
    ext_t acc;
    acc = '0;
    for (int b = 0; b < 3; b++)
      if (((k >> b) & 1) == 1) acc = acc + (ext_t'(p) << b);
    acc = acc >> 3;
    return acc[PER_W-1:0];
  endfunction

  // counter value a channel is loaded with at launch
  function automatic per_t phase_start(per_t p, logic inv, int idx);
    per_t step;
    per_t acc;
    step = eighths(p, 2);
    acc  = '0;
    for (int k = 0; k < NCH; k++)
      if (k < idx) acc = acc + step;
    return inv ? (eighths(p, 6) - acc) : acc;
  endfunction

  function automatic per_t next_count(per_t c, per_t p);
    return (c == p - per_t'(1)) ? '0 : c + per_t'(1);
  endfunction
endpackage

// File: rtl/pwmgrp_ticker.sv
module pwmgrp_ticker #(
  parameter int PRESCALE = 239
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (PRESCALE > 0) ? $clog2(PRESCALE + 1) : 1;
  localparam logic [DW-1:0] LAST = DW'(PRESCALE);

  logic [DW-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + DW'(1);
  end
endmodule

// File: rtl/pwmgrp_seq.sv
module pwmgrp_seq
  import pwmgrp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grp_enable,
  input  logic           grp_start,
  input  logic [NCH-1:0] ch_enable,
  input  per_t           cfg_period,
  input  num_t           cfg_pulses,
  input  logic           cfg_invert,
  input  logic           tick,
  output logic           run,
  output logic           done,
  output logic           launch,
  output per_t           per_q,
  output logic           pol_q,
  output logic           idle_lvl
);
  gstate_e state_q, state_d;
  num_t    num_q;
  per_t    ref_q;
  num_t    prd_q;
  logic    start_ok, zero_req, capture, wrap, finish;

  assign start_ok = grp_enable && grp_start && (&ch_enable);
  assign zero_req = (cfg_pulses == '0);
  assign capture  = (state_q == GS_IDLE) && start_ok;
  assign launch   = capture && !zero_req;
  assign run      = (state_q == GS_RUN);
  assign done     = (state_q == GS_DONE);
  assign wrap     = run && tick && (ref_q == per_q - per_t'(1));
  assign finish   = wrap && (prd_q == num_q - num_t'(1));
  assign idle_lvl = (state_q == GS_IDLE) ? cfg_invert : pol_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GS_IDLE: if (start_ok) state_d = zero_req ? GS_DONE : GS_RUN;
      GS_RUN: begin
        if (!start_ok)   state_d = GS_IDLE;
        else if (finish) state_d = GS_DONE;
      end
      GS_DONE: if (!(grp_enable && grp_start)) state_d = GS_IDLE;
      default: state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      per_q   <= '0;
      num_q   <= '0;
      pol_q   <= 1'b0;
      ref_q   <= '0;
      prd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        per_q <= cfg_period;
        num_q <= cfg_pulses;
        pol_q <= cfg_invert;
        ref_q <= '0;
        prd_q <= '0;
      end else if (run && tick) begin
        ref_q <= next_count(ref_q, per_q);
        if (wrap) prd_q <= prd_q + num_t'(1);
      end
    end
  end
endmodule

// File: rtl/pwmgrp_chan.sv
module pwmgrp_chan
  import pwmgrp_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  input  logic run,
  input  logic idle_lvl,
  input  logic pol,
  input  per_t cfg_period,
  input  logic cfg_invert,
  input  per_t per,
  input  per_t act,
  output logic pwm,
  output per_t cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= phase_start(cfg_period, cfg_invert, IDX);
    else if (run && tick)  cnt <= next_count(cnt, per);
  end

  assign pwm = run ? ((cnt < act) ^ pol) : idle_lvl;
endmodule

// File: rtl/pwm_phase_group.sv
module pwm_phase_group
  import pwmgrp_pkg::*;
#(
  parameter int PRESCALE = 8'hEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [NUM_W-1:0] cfg_pulses,
  input  logic             cfg_invert,
  input  logic             grp_enable,
  input  logic             grp_start,
  input  logic [NCH-1:0]   ch_enable,
  output logic [NCH-1:0]   pwm_out,
  output logic             grp_done
);
  logic run, tick, launch, pol_q, idle_lvl;
  per_t per_q, act_q;
  logic [NCH-1:0][PER_W-1:0] ch_cnt;

  assign act_q = eighths(per_q, 3);

  pwmgrp_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .grp_enable(grp_enable), .grp_start(grp_start), .ch_enable(ch_enable),
    .cfg_period(cfg_period), .cfg_pulses(cfg_pulses), .cfg_invert(cfg_invert),
    .tick(tick), .run(run), .done(grp_done), .launch(launch),
    .per_q(per_q), .pol_q(pol_q), .idle_lvl(idle_lvl)
  );

  pwmgrp_ticker #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmgrp_chan #(.IDX(g)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(launch), .tick(tick), .run(run),
      .idle_lvl(idle_lvl), .pol(pol_q), .cfg_period(cfg_period),
      .cfg_invert(cfg_invert), .per(per_q), .act(act_q),
      .pwm(pwm_out[g]), .cnt(ch_cnt[g])
    );
  end
endmodule

// File: rtl/pwm_phase_group_chk.sv
module pwm_phase_group_chk
  import pwmgrp_pkg::*;
#(
  parameter int PRESCALE = 8'hEF
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      grp_enable,
  input logic                      grp_start,
  input logic [NCH-1:0]            ch_enable,
  input logic                      cfg_invert,
  input logic [NUM_W-1:0]          cfg_pulses,
  input logic [NCH-1:0]            pwm_out,
  input logic                      grp_done,
  input logic                      run,
  input logic                      tick,
  input logic                      pol_q,
  input logic [PER_W-1:0]          per_q,
  input logic [NCH-1:0][PER_W-1:0] ch_cnt
);
  logic        gates_on;
  logic [31:0] gap_q;

  assign gates_on = grp_enable && grp_start && (&ch_enable);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) gap_q <= '0;
    else                        gap_q <= gap_q + 32'd1;
  end

  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !grp_done) |-> (pwm_out == {NCH{cfg_invert}}));

  assert_done_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> (pwm_out == {NCH{pol_q}}));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done && grp_enable && grp_start) |=> grp_done);

  assert_no_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !gates_on) |=> !run);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !gates_on) |=> (!run && !grp_done));

  assert_zero_pulses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !grp_done && gates_on && cfg_pulses == '0) |=> (grp_done && !run));

  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(per_q) && $stable(pol_q)));

  assert_tick_on_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |-> (gap_q == 32'(PRESCALE)));

  assert_tick_not_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |-> (gap_q < 32'(PRESCALE)));

  for (genvar g = 0; g < NCH; g++) begin : g_rng
    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ch_cnt[g] < per_q));
  end
endmodule

bind pwm_phase_group pwm_phase_group_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_enable(grp_enable), .grp_start(grp_start),
  .ch_enable(ch_enable), .cfg_invert(cfg_invert), .cfg_pulses(cfg_pulses),
  .pwm_out(pwm_out), .grp_done(grp_done), .run(run), .tick(tick),
  .pol_q(pol_q), .per_q(per_q), .ch_cnt(ch_cnt)
);

// File: tb/pwm_phase_group_test.sv
`timescale 1ns/1ps
module pwm_phase_group_test;
  localparam int TB_PRESCALE = 3;
  localparam int D = TB_PRESCALE + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_period = 16'd16;
  logic [15:0] cfg_pulses = 16'd1;
  logic        cfg_invert = 1'b0;
  logic        grp_enable = 1'b0;
  logic        grp_start = 1'b0;
  logic [3:0]  ch_enable = 4'h0;
  logic [3:0]  pwm_out;
  logic        grp_done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_phase_group #(.PRESCALE(TB_PRESCALE)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_pulses(cfg_pulses),
    .cfg_invert(cfg_invert), .grp_enable(grp_enable), .grp_start(grp_start),
    .ch_enable(ch_enable), .pwm_out(pwm_out), .grp_done(grp_done)
  );

  // expected outputs at tick j of a run, written from the requirements
  function automatic logic [3:0] expect_pwm(int p, bit inv, int j);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      int s;
      int c;
      s = inv ? ((p * 6) / 8 - i * ((p * 2) / 8)) : i * ((p * 2) / 8);
      c = (s + j) % p;
      r[i] = (c < (p * 3) / 8) ^ inv;
    end
    return r;
  endfunction

  task automatic check4(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pwm_out=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic check1(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s grp_done=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check4("R1 outputs in reset", pwm_out, 4'h0);
    check1("R1 done in reset", grp_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check4("R1 outputs after reset", pwm_out, 4'h0);
    check1("R1 done after reset", grp_done, 1'b0);
  endtask

  // full run with a per-tick comparison; disturb changes config mid-run
  task automatic t_run(int p, int n, bit inv, bit disturb);
    string tag;
    tag = inv ? "R4 inverted phase" : "R3/R5 normal phase";
    @(negedge clk);
    cfg_period = 16'(p); cfg_pulses = 16'(n); cfg_invert = inv;
    grp_enable = 1'b1; ch_enable = 4'hF; grp_start = 1'b1;
    @(posedge clk);
    for (int j = 0; j < p * n; j++) begin
      @(negedge clk);
      check4(disturb ? "R10 pattern after cfg change" : tag, pwm_out, expect_pwm(p, inv, j));
      if (disturb && j == 1) begin
        cfg_period = 16'(p + 8); cfg_pulses = 16'(n + 3); cfg_invert = !inv;
      end
      repeat (D - 1) @(negedge clk);
      check4("R6 hold within tick", pwm_out, expect_pwm(p, inv, j));
      check1("R7 done low while running", grp_done, 1'b0);
    end
    @(negedge clk);
    check1("R7 done after N*P ticks", grp_done, 1'b1);
    check4("R7 inactive when done", pwm_out, {4{inv}});
    repeat (5) @(negedge clk);
    check1("R7 done holds", grp_done, 1'b1);
    check4("R7 outputs hold inactive", pwm_out, {4{inv}});
    grp_start = 1'b0;
    @(negedge clk);
    check1("R11 done clears on stop", grp_done, 1'b0);
    check4("R11 idle follows live polarity", pwm_out, {4{cfg_invert}});
    cfg_invert = 1'b0;
    @(negedge clk);
    check4("R11 idle follows live polarity low", pwm_out, 4'h0);
  endtask

  task automatic t_gating();
    @(negedge clk);
    cfg_period = 16'd16; cfg_pulses = 16'd4; cfg_invert = 1'b0;
    grp_enable = 1'b1; ch_enable = 4'b0111; grp_start = 1'b1;
    repeat (6) @(negedge clk);
    check4("R2 no launch with three channels", pwm_out, 4'h0);
    check1("R2 no done with three channels", grp_done, 1'b0);
    ch_enable = 4'hF; grp_enable = 1'b0;
    repeat (6) @(negedge clk);
    check4("R2 no launch without group enable", pwm_out, 4'h0);
    grp_enable = 1'b1;
    @(negedge clk);
    check4("R2 launch first pattern", pwm_out, expect_pwm(16, 1'b0, 0));
    ch_enable = 4'b1110;
    @(negedge clk);
    check4("R9 abort on channel enable drop", pwm_out, 4'h0);
    check1("R9 no done after abort", grp_done, 1'b0);
    ch_enable = 4'hF;
    @(negedge clk);
    check4("R2 relaunch first pattern", pwm_out, expect_pwm(16, 1'b0, 0));
    repeat (D) @(negedge clk);
    check4("R2 relaunch second tick", pwm_out, expect_pwm(16, 1'b0, 1));
    grp_start = 1'b0;
    @(negedge clk);
    check4("R9 abort on start drop", pwm_out, 4'h0);
    check1("R9 done low after start drop", grp_done, 1'b0);
  endtask

  task automatic t_zero();
    @(negedge clk);
    cfg_period = 16'd16; cfg_pulses = 16'd0; cfg_invert = 1'b1;
    grp_enable = 1'b1; ch_enable = 4'hF; grp_start = 1'b1;
    @(negedge clk);
    check1("R8 zero count completes at once", grp_done, 1'b1);
    check4("R8 zero count never active", pwm_out, 4'hF);
    repeat (4 * D) @(negedge clk);
    check4("R8 still inactive", pwm_out, 4'hF);
    grp_start = 1'b0; cfg_invert = 1'b0;
    @(negedge clk);
    check1("R8 cleared", grp_done, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_run(16, 2, 1'b0, 1'b1);
    t_run(16, 1, 1'b1, 1'b0);
    t_run(20, 1, 1'b1, 1'b0);
    t_run(24, 1, 1'b0, 1'b0);
    t_gating();
    t_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule